// File: doc/BRIEF.md
# I2C Slave Own-Address Recognizer

This block sits behind an I2C bit-level front end that has already turned the wire activity into events: a START strobe (a repeated START looks the same), a STOP strobe, and a strobe with each received byte. For each byte the slave has to answer, the block decides between ACK and NACK, one cycle after the byte strobe. It also keeps the addressing state: whether this slave is selected, the transfer direction, and whether the transfer is a general call.

The own address can be 7-bit or 10-bit, chosen at run time. In 10-bit mode the block remembers a finished write addressing, which lets a master switch to a read with a repeated START and only the prefix byte. General-call second bytes can raise one-cycle command pulses. The START byte is never acknowledged. A response-disable input makes the slave refuse data bytes, which ends a write. When an address does not match, the block ignores all bytes until the next START.

Top module: `own_addr_filter`

## Requirements
- R1: In 7-bit mode (cfg_ten_bit=0), the first byte after a START is acknowledged when bits 7:1 equal cfg_addr[6:0]. The block then sets addressed=1 and sets rd_dir to bit 0 of that byte (1 = read).
- R2: A first byte that matches nothing gets NACK (ack_vld=1, ack=0) and leaves addressed=0. After that, no byte produces ack_vld until the next START.
- R3: In 10-bit mode (cfg_ten_bit=1), a write prefix 11110 followed by cfg_addr[9:8] and a 0 bit is acknowledged without setting addressed. The next byte is acknowledged only if it equals cfg_addr[7:0]. It then sets addressed=1 and rd_dir=0. A different low byte is refused.
- R4: After a 10-bit write addressing is complete, a repeated START followed by the prefix 11110, cfg_addr[9:8] and a 1 bit is acknowledged with no low byte. It sets addressed=1 and rd_dir=1.
- R5: A 10-bit read prefix is refused in two cases: when no write addressing of this slave came before it, and when its bits 2:1 differ from cfg_addr[9:8].
- R6: The first byte 0x00 is acknowledged and sets gen_call=1 and addressed=1. In the cycle that acknowledges the second byte, 0x06 raises gc_rst_pulse and 0x04 raises gc_prog_pulse. Any other second byte is acknowledged with no pulse. Later data bytes raise no pulse.
- R7: The first byte 0x01 (START byte) is always refused. A repeated START that follows it and carries the own address is acknowledged.
- R8: While resp_dis=1, data bytes of an addressed write receive ack_vld=1 with ack=0.
- R9: A STOP clears addressed, gen_call and rd_dir, and forgets the 10-bit write addressing. A later read prefix is therefore refused.
- R10: ack_vld pulses exactly one cycle after a byte strobe that the slave must answer. Bytes during a read transfer, and a byte strobe in the same cycle as START or STOP, produce no ack_vld.
- R11: Reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_start | input | 1 | START or repeated START seen |
| ev_stop | input | 1 | STOP seen |
| byte_vld | input | 1 | Received byte strobe |
| byte_data | input | 8 | Received byte, MSB first on the wire |
| cfg_ten_bit | input | 1 | 1 selects 10-bit own address |
| cfg_addr | input | 10 | Own address (7-bit mode uses bits 6:0) |
| resp_dis | input | 1 | Refuse data bytes while high |
| ack_vld | output | 1 | ACK decision valid this cycle |
| ack | output | 1 | 1 = acknowledge, 0 = NACK |
| addressed | output | 1 | Slave selected for the current transfer |
| rd_dir | output | 1 | 1 = master reads from this slave |
| gen_call | output | 1 | Current transfer is a general call |
| gc_rst_pulse | output | 1 | General-call reset-and-program command |
| gc_prog_pulse | output | 1 | General-call program-only command |

## Verification
The bench builds the block with the 10-bit path and general-call support both enabled, and it uses the default command codes 0x06 and 0x04. Because the 10-bit path is present, switching cfg_ten_bit between transfers exercises both address formats in one build. The own address 0x3A8 gives the 7-bit byte 0x50/0x51 and the 10-bit prefixes 0xF6/0xF7. Prefixes 0xF4/0xF5 supply the mismatched upper bits.

// File: rtl/own_addr_pkg.sv
package own_addr_pkg;

   localparam int BYTE_W = 8;
   localparam int OWN_W  = 10;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_FIRST,
      PH_TENLOW,
      PH_GC2,
      PH_WRITE,
      PH_READ,
      PH_SKIP
   } phase_e;

   typedef enum logic [2:0] {
      FB_NONE,
      FB_GCALL,
      FB_STBYTE,
      FB_MATCH7,
      FB_TENWR,
      FB_TENRD
   } fb_kind_e;

endpackage

// File: rtl/addr_byte_classify.sv
module addr_byte_classify
   import own_addr_pkg::*;
#(
   parameter bit TEN_BIT_EN = 1'b1,
   parameter bit GC_EN      = 1'b1
) (
   input  logic [BYTE_W-1:0] byte_data,
   input  logic              ten_mode,
   input  logic [OWN_W-1:0]  own_addr,
   input  logic              ten_mem,
   output fb_kind_e          kind
);

   localparam logic [4:0] TEN_PFX = 5'b11110;

   fb_kind_e addr_kind;

   generate
      if (TEN_BIT_EN) begin : g_ten
         always_comb begin
            addr_kind = FB_NONE;
            if (ten_mode) begin
               if (byte_data[7:3] == TEN_PFX && byte_data[2:1] == own_addr[9:8]) begin
                  if (!byte_data[0])
                     addr_kind = FB_TENWR;
                  else if (ten_mem)
                     addr_kind = FB_TENRD;
               end
            end else if (byte_data[7:1] == own_addr[6:0]) begin
               addr_kind = FB_MATCH7;
            end
         end
      end else begin : g_seven
         always_comb begin
            addr_kind = FB_NONE;
            if (byte_data[7:1] == own_addr[6:0])
               addr_kind = FB_MATCH7;
         end
      end
   endgenerate

   always_comb begin
      if (byte_data == '0)
         kind = GC_EN ? FB_GCALL : FB_NONE;
      else if (byte_data == BYTE_W'(1))
         kind = FB_STBYTE;
      else
         kind = addr_kind;
   end

endmodule

// File: rtl/gc_cmd_decode.sv
module gc_cmd_decode
   import own_addr_pkg::*;
#(
   parameter logic [BYTE_W-1:0] RST_CODE  = 8'h06,
   parameter logic [BYTE_W-1:0] PROG_CODE = 8'h04
) (
   input  logic [BYTE_W-1:0] cmd_byte,
   output logic              is_rst,
   output logic              is_prog
);

   generate
      if (RST_CODE == PROG_CODE) begin : g_bad_codes
         $error("gc_cmd_decode: command codes must differ");
      end
   endgenerate

   assign is_rst  = (cmd_byte == RST_CODE);
   assign is_prog = (cmd_byte == PROG_CODE);

endmodule

// File: rtl/own_addr_filter.sv
module own_addr_filter
   import own_addr_pkg::*;
#(
   parameter bit                TEN_BIT_EN   = 1'b1,
   parameter bit                GC_EN        = 1'b1,
   parameter logic [BYTE_W-1:0] GC_RST_CODE  = 8'h06,
   parameter logic [BYTE_W-1:0] GC_PROG_CODE = 8'h04
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              byte_vld,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic              cfg_ten_bit,
   input  logic [OWN_W-1:0]  cfg_addr,
   input  logic              resp_dis,
   output logic              ack_vld,
   output logic              ack,
   output logic              addressed,
   output logic              rd_dir,
   output logic              gen_call,
   output logic              gc_rst_pulse,
   output logic              gc_prog_pulse
);

   phase_e   phase_q;
   logic     ten_mem_q;
   fb_kind_e fb_kind;
   logic     cmd_rst, cmd_prog;
   logic     ten_mode;

   assign ten_mode = TEN_BIT_EN && cfg_ten_bit;

   addr_byte_classify #(
      .TEN_BIT_EN (TEN_BIT_EN),
      .GC_EN      (GC_EN)
   ) u_classify (
      .byte_data (byte_data),
      .ten_mode  (ten_mode),
      .own_addr  (cfg_addr),
      .ten_mem   (ten_mem_q),
      .kind      (fb_kind)
   );

   gc_cmd_decode #(
      .RST_CODE  (GC_RST_CODE),
      .PROG_CODE (GC_PROG_CODE)
   ) u_gc_cmd (
      .cmd_byte (byte_data),
      .is_rst   (cmd_rst),
      .is_prog  (cmd_prog)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q       <= PH_IDLE;
         ten_mem_q     <= 1'b0;
         ack_vld       <= 1'b0;
         ack           <= 1'b0;
         addressed     <= 1'b0;
         rd_dir        <= 1'b0;
         gen_call      <= 1'b0;
         gc_rst_pulse  <= 1'b0;
         gc_prog_pulse <= 1'b0;
      end else begin
         ack_vld       <= 1'b0;
         ack           <= 1'b0;
         gc_rst_pulse  <= 1'b0;
         gc_prog_pulse <= 1'b0;
         if (ev_stop) begin
            phase_q   <= PH_IDLE;
            ten_mem_q <= 1'b0;
            addressed <= 1'b0;
            rd_dir    <= 1'b0;
            gen_call  <= 1'b0;
         end else if (ev_start) begin
            phase_q   <= PH_FIRST;
            addressed <= 1'b0;
            rd_dir    <= 1'b0;
            gen_call  <= 1'b0;
         end else if (byte_vld) begin
            unique case (phase_q)
               PH_FIRST: begin
                  ack_vld <= 1'b1;
                  if (fb_kind != FB_TENRD)
                     ten_mem_q <= 1'b0;
                  unique case (fb_kind)
                     FB_GCALL: begin
                        ack       <= 1'b1;
                        addressed <= 1'b1;
                        gen_call  <= 1'b1;
                        phase_q   <= PH_GC2;
                     end
                     FB_MATCH7: begin
                        ack       <= 1'b1;
                        addressed <= 1'b1;
                        rd_dir    <= byte_data[0];
                        phase_q   <= byte_data[0] ? PH_READ : PH_WRITE;
                     end
                     FB_TENWR: begin
                        ack     <= 1'b1;
                        phase_q <= PH_TENLOW;
                     end
                     FB_TENRD: begin
                        ack       <= 1'b1;
                        addressed <= 1'b1;
                        rd_dir    <= 1'b1;
                        phase_q   <= PH_READ;
                     end
                     default: phase_q <= PH_SKIP;
                  endcase
               end
               PH_TENLOW: begin
                  ack_vld <= 1'b1;
                  if (byte_data == cfg_addr[BYTE_W-1:0]) begin
                     ack       <= 1'b1;
                     addressed <= 1'b1;
                     ten_mem_q <= 1'b1;
                     phase_q   <= PH_WRITE;
                  end else begin
                     phase_q <= PH_SKIP;
                  end
               end
               PH_GC2: begin
                  ack_vld       <= 1'b1;
                  ack           <= !resp_dis;
                  gc_rst_pulse  <= !resp_dis && cmd_rst;
                  gc_prog_pulse <= !resp_dis && cmd_prog;
                  phase_q       <= PH_WRITE;
               end
               PH_WRITE: begin
                  ack_vld <= 1'b1;
                  ack     <= !resp_dis;
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/own_addr_filter_chk.sv
module own_addr_filter_chk
   import own_addr_pkg::*;
(
   input logic              clk,
   input logic              rst_n,
   input logic              ev_start,
   input logic              ev_stop,
   input logic              byte_vld,
   input logic [BYTE_W-1:0] byte_data,
   input logic              resp_dis,
   input logic              cfg_ten_bit,
   input logic              ack_vld,
   input logic              ack,
   input logic              addressed,
   input logic              rd_dir,
   input logic              gen_call,
   input logic              gc_rst_pulse,
   input logic              gc_prog_pulse,
   input phase_e            phase,
   input logic              ten_mem
);

   logic plain_byte;
   assign plain_byte = byte_vld && !ev_start && !ev_stop;

   AST_ACK_FOLLOWS_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      ack_vld |-> $past(byte_vld) && !$past(ev_start) && !$past(ev_stop)); // R10

   AST_READ_NO_ACKVLD: assert property (@(posedge clk) disable iff (!rst_n)
      plain_byte && phase == PH_READ |=> !ack_vld); // R10

   AST_RD_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_dir) |-> addressed); // R1

   AST_SKIP_UNSELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      phase == PH_SKIP |-> !addressed); // R2

   AST_TEN_READ_NEEDS_MEM: assert property (@(posedge clk) disable iff (!rst_n)
      plain_byte && phase == PH_FIRST && cfg_ten_bit && !ten_mem &&
      byte_data[7:3] == 5'b11110 && byte_data[0] |=> ack_vld && !ack); // R5

   AST_GC_PULSE_IN_GC: assert property (@(posedge clk) disable iff (!rst_n)
      (gc_rst_pulse || gc_prog_pulse) |-> gen_call && ack_vld && ack); // R6

   AST_START_BYTE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      plain_byte && phase == PH_FIRST && byte_data == 8'h01 |=> ack_vld && !ack); // R7

   AST_RESP_DIS_NACK: assert property (@(posedge clk) disable iff (!rst_n)
      plain_byte && resp_dis && phase == PH_WRITE |=> ack_vld && !ack); // R8

   AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> !addressed && !gen_call && !ten_mem); // R9

endmodule

bind own_addr_filter own_addr_filter_chk u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .ev_start      (ev_start),
   .ev_stop       (ev_stop),
   .byte_vld      (byte_vld),
   .byte_data     (byte_data),
   .resp_dis      (resp_dis),
   .cfg_ten_bit   (cfg_ten_bit),
   .ack_vld       (ack_vld),
   .ack           (ack),
   .addressed     (addressed),
   .rd_dir        (rd_dir),
   .gen_call      (gen_call),
   .gc_rst_pulse  (gc_rst_pulse),
   .gc_prog_pulse (gc_prog_pulse),
   .phase         (phase_q),
   .ten_mem       (ten_mem_q)
);

// File: tb/sim_own_addr_filter.sv
module sim_own_addr_filter;

   localparam logic [1:0] KS = 2'd0;  // START
   localparam logic [1:0] KP = 2'd1;  // STOP
   localparam logic [1:0] KB = 2'd2;  // byte
   localparam int NV = 61;

   // {mode, kind, dis, data, req, {ack_vld, ack, addressed, rd_dir, gen_call, rst_pulse, prog_pulse}}
   localparam logic [22:0] VEC [NV] = '{
      {1'b0, KS, 1'b0, 8'h00, 4'd1,  7'b0000000},
      {1'b0, KB, 1'b0, 8'h50, 4'd1,  7'b1110000},  // R1 write select
      {1'b0, KB, 1'b0, 8'h33, 4'd8,  7'b1110000},
      {1'b0, KB, 1'b1, 8'h44, 4'd8,  7'b1010000},  // R8 refused data
      {1'b0, KP, 1'b0, 8'h00, 4'd9,  7'b0000000},
      {1'b0, KS, 1'b0, 8'h00, 4'd1,  7'b0000000},
      {1'b0, KB, 1'b0, 8'h51, 4'd1,  7'b1111000},  // R1 read select
      {1'b0, KB, 1'b0, 8'h99, 4'd10, 7'b0011000},  // R10 read byte silent
      {1'b0, KP, 1'b0, 8'h00, 4'd9,  7'b0000000},
      {1'b0, KS, 1'b0, 8'h00, 4'd2,  7'b0000000},
      {1'b0, KB, 1'b0, 8'h52, 4'd2,  7'b1000000},  // R2 mismatch
      {1'b0, KB, 1'b0, 8'h50, 4'd2,  7'b0000000},  // R2 ignored
      {1'b0, KP, 1'b0, 8'h00, 4'd2,  7'b0000000},
      {1'b0, KS, 1'b0, 8'h00, 4'd6,  7'b0000000},
      {1'b0, KB, 1'b0, 8'h00, 4'd6,  7'b1110100},  // R6 general call
      {1'b0, KB, 1'b0, 8'h06, 4'd6,  7'b1110110},
      {1'b0, KB, 1'b0, 8'h04, 4'd6,  7'b1110100},
      {1'b0, KP, 1'b0, 8'h00, 4'd9,  7'b0000000},
      {1'b0, KS, 1'b0, 8'h00, 4'd6,  7'b0000000},
      {1'b0, KB, 1'b0, 8'h00, 4'd6,  7'b1110100},
      {1'b0, KB, 1'b0, 8'h04, 4'd6,  7'b1110101},
      {1'b0, KP, 1'b0, 8'h00, 4'd6,  7'b0000000},
      {1'b0, KS, 1'b0, 8'h00, 4'd6,  7'b0000000},
      {1'b0, KB, 1'b0, 8'h00, 4'd6,  7'b1110100},
      {1'b0, KB, 1'b0, 8'h09, 4'd6,  7'b1110100},
      {1'b0, KP, 1'b0, 8'h00, 4'd6,  7'b0000000},
      {1'b0, KS, 1'b0, 8'h00, 4'd7,  7'b0000000},
      {1'b0, KB, 1'b0, 8'h01, 4'd7,  7'b1000000},  // R7 START byte
      {1'b0, KS, 1'b0, 8'h00, 4'd7,  7'b0000000},
      {1'b0, KB, 1'b0, 8'h50, 4'd7,  7'b1110000},
      {1'b0, KP, 1'b0, 8'h00, 4'd7,  7'b0000000},
      {1'b1, KS, 1'b0, 8'h00, 4'd3,  7'b0000000},
      {1'b1, KB, 1'b0, 8'hF6, 4'd3,  7'b1100000},  // R3 write prefix
      {1'b1, KB, 1'b0, 8'hA8, 4'd3,  7'b1110000},
      {1'b1, KB, 1'b0, 8'h5A, 4'd3,  7'b1110000},
      {1'b1, KS, 1'b0, 8'h00, 4'd4,  7'b0000000},
      {1'b1, KB, 1'b0, 8'hF7, 4'd4,  7'b1111000},  // R4 combined read
      {1'b1, KP, 1'b0, 8'h00, 4'd4,  7'b0000000},
      {1'b1, KS, 1'b0, 8'h00, 4'd5,  7'b0000000},
      {1'b1, KB, 1'b0, 8'hF7, 4'd5,  7'b1000000},  // R5 read prefix first
      {1'b1, KP, 1'b0, 8'h00, 4'd5,  7'b0000000},
      {1'b1, KS, 1'b0, 8'h00, 4'd5,  7'b0000000},
      {1'b1, KB, 1'b0, 8'hF6, 4'd5,  7'b1100000},
      {1'b1, KB, 1'b0, 8'hA8, 4'd5,  7'b1110000},
      {1'b1, KS, 1'b0, 8'h00, 4'd5,  7'b0000000},
      {1'b1, KB, 1'b0, 8'hF5, 4'd5,  7'b1000000},  // R5 other upper bits
      {1'b1, KP, 1'b0, 8'h00, 4'd5,  7'b0000000},
      {1'b1, KS, 1'b0, 8'h00, 4'd3,  7'b0000000},
      {1'b1, KB, 1'b0, 8'hF6, 4'd3,  7'b1100000},
      {1'b1, KB, 1'b0, 8'hA9, 4'd3,  7'b1000000},  // R3 low mismatch
      {1'b1, KP, 1'b0, 8'h00, 4'd3,  7'b0000000},
      {1'b1, KS, 1'b0, 8'h00, 4'd9,  7'b0000000},
      {1'b1, KB, 1'b0, 8'hF6, 4'd9,  7'b1100000},
      {1'b1, KB, 1'b0, 8'hA8, 4'd9,  7'b1110000},
      {1'b1, KP, 1'b0, 8'h00, 4'd9,  7'b0000000},
      {1'b1, KS, 1'b0, 8'h00, 4'd9,  7'b0000000},
      {1'b1, KB, 1'b0, 8'hF7, 4'd9,  7'b1000000},  // R9 memory forgotten
      {1'b1, KP, 1'b0, 8'h00, 4'd9,  7'b0000000},
      {1'b0, KS, 1'b0, 8'h00, 4'd2,  7'b0000000},
      {1'b0, KB, 1'b0, 8'hF6, 4'd2,  7'b1000000},  // R2 prefix in 7-bit mode
      {1'b0, KP, 1'b0, 8'h00, 4'd2,  7'b0000000}
   };

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ev_start = 1'b0, ev_stop = 1'b0, byte_vld = 1'b0;
   logic [7:0] byte_data = '0;
   logic       cfg_ten_bit = 1'b0;
   logic [9:0] cfg_addr = 10'h3A8;
   logic       resp_dis = 1'b0;
   logic       ack_vld, ack, addressed, rd_dir, gen_call, gc_rst_pulse, gc_prog_pulse;
   int         checks = 0;
   int         errors = 0;
   bit         finished = 1'b0;

   always #10 clk = ~clk;

   own_addr_filter u0 (
      .clk           (clk),
      .rst_n         (rst_n),
      .ev_start      (ev_start),
      .ev_stop       (ev_stop),
      .byte_vld      (byte_vld),
      .byte_data     (byte_data),
      .cfg_ten_bit   (cfg_ten_bit),
      .cfg_addr      (cfg_addr),
      .resp_dis      (resp_dis),
      .ack_vld       (ack_vld),
      .ack           (ack),
      .addressed     (addressed),
      .rd_dir        (rd_dir),
      .gen_call      (gen_call),
      .gc_rst_pulse  (gc_rst_pulse),
      .gc_prog_pulse (gc_prog_pulse)
   );

   function automatic logic [6:0] outs();
      return {ack_vld, ack, addressed, rd_dir, gen_call, gc_rst_pulse, gc_prog_pulse};
   endfunction

   task automatic check(input int req, input int idx, input logic [6:0] exp);
      checks++;
      if (outs() !== exp) begin
         errors++;
         $display("FAIL R%0d step %0d: got %b expected %b", req, idx, outs(), exp);
      end
   endtask

   // drive at a falling edge, let one rising edge register it, sample at the next falling edge
   task automatic step(input logic mode, input logic [1:0] kind, input logic dis,
                       input logic [7:0] data);
      cfg_ten_bit = mode;
      resp_dis    = dis;
      byte_data   = data;
      ev_start    = (kind == KS);
      ev_stop     = (kind == KP);
      byte_vld    = (kind == KB);
      @(posedge clk);
      @(negedge clk);
      ev_start = 1'b0;
      ev_stop  = 1'b0;
      byte_vld = 1'b0;
      resp_dis = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(11, 0, 7'b0000000);  // R11 reset state
      rst_n = 1'b1;
      @(negedge clk);
      check(11, 0, 7'b0000000);  // R11 after release

      for (int i = 0; i < NV; i++) begin
         step(VEC[i][22], VEC[i][21:20], VEC[i][19], VEC[i][18:11]);
         check(int'(VEC[i][10:7]), i + 1, VEC[i][6:0]);
      end

      // R10: byte strobe coincident with START is dropped
      cfg_ten_bit = 1'b0;
      byte_data   = 8'h50;
      ev_start    = 1'b1;
      byte_vld    = 1'b1;
      @(posedge clk);
      @(negedge clk);
      ev_start = 1'b0;
      byte_vld = 1'b0;
      check(10, 100, 7'b0000000);
      step(1'b0, KB, 1'b0, 8'h50);
      check(1, 101, 7'b1110000);  // R1 still awaiting the address

      // R8: refusal also applies to the general-call second byte, no pulse
      step(1'b0, KP, 1'b0, 8'h00);
      step(1'b0, KS, 1'b0, 8'h00);
      step(1'b0, KB, 1'b0, 8'h00);
      step(1'b0, KB, 1'b1, 8'h06);
      check(8, 102, 7'b1010100);

      // R11: reset in the middle of a selected transfer
      step(1'b0, KS, 1'b0, 8'h00);
      step(1'b0, KB, 1'b0, 8'h51);
      check(1, 103, 7'b1111000);
      rst_n = 1'b0;
      @(negedge clk);
      check(11, 104, 7'b0000000);
      rst_n = 1'b1;
      @(negedge clk);
      step(1'b0, KB, 1'b0, 8'h50);  // no START since reset: ignored
      check(11, 105, 7'b0000000);

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: run did not complete");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule